// File: doc/BRIEF.md
# Dual-Side Integrator Offset and Gain Corrector

This block corrects a stream of raw conversion results from a charge-integrating front end. Each analog input is served by two integrators that take turns, so consecutive samples of one input come from different circuits, with different offsets and gains. Every sample carries an input number and a side tag (A or B). The block looks up the coefficient pair for that side, subtracts the offset, multiplies the difference by the gain and sends out a saturated signed result two cycles later.

Coefficients come from a register write port or from two self-calibration sequences. The zero-level sequence averages 256 samples per side and stores each mean as that side's offset, then switches correction on. The full-scale sequence averages 256 samples per side, removes the stored offsets, and sets each B-side gain to the ratio of the A-side level to the B-side level. The ratio comes from a bit-serial divider, and output valid is held low while that divider runs. A global enable chooses between corrected output and raw pass-through. Switching the enable does not touch the stored coefficients.

Top module: `dualside_cal`

## Requirements
- R1: After reset, out_valid, cal_active and af_done are 0, every offset is 0 and every gain is unity (65536). Once correction is switched on, a sample therefore comes out equal to its raw value.
- R2: With correction on, a sample accepted on a clock edge appears two edges later as out_valid=1 and out_data = floor((raw - offset) * gain / 65536). The subtraction is done in signed arithmetic before the multiply.
- R3: Coefficient slot = {in_chan, in_side}, where side 0 is A and side 1 is B. Alternating A/B samples each use their own slot's pair.
- R4: With correction off, out_data is the raw value zero-extended. Turning correction off and on again reuses the stored coefficients unchanged.
- R5: A write with wr_gain=1 loads wr_data[17:0] as an unsigned Q2.16 gain. A write with wr_gain=0 loads wr_data as the offset, into slot {wr_chan, wr_side}. A sample presented in the same cycle as the write still uses the old value, and the next sample uses the new one.
- R6: out_data is a 24-bit signed value that saturates at its limits instead of wrapping. The extreme inputs (raw 0xFFFFF or 0 against offset 0 or 0xFFFFF, gain 0x3FFFF) give exact results.
- R7: An af_offset_go pulse starts averaging. Each slot accepts its first 256 samples and ignores any later ones. Each offset becomes the slot's sum shifted right by 8, and correction is switched on.
- R8: af_done goes low after a start pulse, stays low while averaging or dividing, and goes high when the sequence completes. It stays high until the next start pulse.
- R9: An af_gain_go pulse averages 256 samples per slot. Each B gain then becomes floor(((meanA - offA) * 65536) / (meanB - offB)), with a difference below zero taken as 0, and is clamped to 0x3FFFF. A gains and all offsets stay unchanged.
- R10: While the gain divider is running, out_valid stays 0 even for samples that arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Raw sample present |
| in_chan | input | 1 | Input number of the sample |
| in_side | input | 1 | Integrator side, 0 = A, 1 = B |
| in_raw | input | 20 | Unsigned raw sample |
| wr_en | input | 1 | Coefficient write strobe |
| wr_chan | input | 1 | Input number of the written slot |
| wr_side | input | 1 | Side of the written slot |
| wr_gain | input | 1 | 1 = gain write, 0 = offset write |
| wr_data | input | 20 | Coefficient value |
| cal_on_stb | input | 1 | Switch correction on |
| cal_off_stb | input | 1 | Switch correction off |
| af_offset_go | input | 1 | Start zero-level offset learning |
| af_gain_go | input | 1 | Start full-scale gain matching |
| af_done | output | 1 | Last learning sequence finished |
| cal_active | output | 1 | Correction currently applied |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | 24 | Signed corrected sample |

## Verification
Two events can land on the same edge: a coefficient write and a sample that needs that coefficient. The bench drives a sample and an offset write to the same slot in one cycle. It requires the result to match the old offset and the sample after it to match the new one. It also sends a sample one cycle after the full-scale averaging completes, so that it lands on the first divider cycle, and requires that no valid output appears for it. Every other expected value is computed arithmetically from the bench's own coefficient model over sweeps of raw values across all four slots.

// File: rtl/dcal_pkg.sv
// Shared types for the dual-side calibrator.
// Assumes: nothing beyond IEEE 1800-2017.
package dcal_pkg;
    typedef enum logic [1:0] {
        AF_IDLE,
        AF_OFFSET,
        AF_GAIN,
        AF_DIVIDE
    } af_state_e;
endpackage

// File: rtl/dcal_coef_bank.sv
// Coefficient store: one offset and one gain per slot.
// Written by the register port and by the learning engine. A learning
// load issued in the same cycle as a port write wins.
// Assumes GAIN_W <= RAW_W, so a gain fits in the low bits of wr_data.
module dcal_coef_bank #(
    parameter int N_SLOT = 4,
    parameter int RAW_W  = 20,
    parameter int GAIN_W = 18,
    parameter int FRAC   = 16,
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SLOT_W-1:0]              wr_slot,
    input  logic                           wr_gain,
    input  logic [RAW_W-1:0]               wr_data,
    input  logic                           off_load,
    input  logic [N_SLOT-1:0][RAW_W-1:0]   off_mean,
    input  logic                           gain_load,
    input  logic [SLOT_W-1:0]              gain_slot,
    input  logic [GAIN_W-1:0]              gain_val,
    output logic [N_SLOT-1:0][RAW_W-1:0]   offset,
    output logic [N_SLOT-1:0][GAIN_W-1:0]  gain
);
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC;

    logic [RAW_W-1:0]  off_q  [N_SLOT];
    logic [GAIN_W-1:0] gain_q [N_SLOT];

    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        // Holds and updates the pair for slot i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_q[i]  <= '0;
                gain_q[i] <= UNITY;
            end else begin
                if (wr_en && wr_slot == SLOT_W'(i)) begin
                    if (wr_gain) gain_q[i] <= wr_data[GAIN_W-1:0];
                    else         off_q[i]  <= wr_data;
                end
                if (off_load)                             off_q[i]  <= off_mean[i];
                if (gain_load && gain_slot == SLOT_W'(i)) gain_q[i] <= gain_val;
            end
        end
        assign offset[i] = off_q[i];
        assign gain[i]   = gain_q[i];
    end
endmodule

// File: rtl/dcal_datapath.sv
// Two-stage correction pipe. Stage one snapshots the sample together with
// its coefficients and the enable, so a later write cannot reach a
// multiply already under way. Stage two computes (raw - off) * gain,
// scales it, saturates it and registers it.
// Assumes OUT_W > RAW_W and RAW_W + GAIN_W + 2 >= OUT_W.
module dcal_datapath #(
    parameter int RAW_W  = 20,
    parameter int GAIN_W = 18,
    parameter int FRAC   = 16,
    parameter int OUT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [RAW_W-1:0]  in_raw,
    input  logic [RAW_W-1:0]  coef_off,
    input  logic [GAIN_W-1:0] coef_gain,
    input  logic              cal_en,
    input  logic              hold,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);
    localparam int PW = RAW_W + GAIN_W + 2;
    localparam logic signed [PW-1:0] MAXV = {{(PW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = ~MAXV;

    logic              s1_valid, s1_en;
    logic [RAW_W-1:0]  s1_raw, s1_off;
    logic [GAIN_W-1:0] s1_gain;
    logic signed [RAW_W:0] diff;
    logic signed [PW-1:0]  prod, scaled;
    logic [OUT_W-1:0]      result;

    // Stage one: capture the sample with the coefficients in force now.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_en    <= 1'b0;
            s1_raw   <= '0;
            s1_off   <= '0;
            s1_gain  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_en   <= cal_en;
                s1_raw  <= in_raw;
                s1_off  <= coef_off;
                s1_gain <= coef_gain;
            end
        end
    end

    // Subtract first, multiply, floor-scale, then clamp to the output range.
    always_comb begin
        diff   = $signed({1'b0, s1_raw}) - $signed({1'b0, s1_off});
        prod   = diff * $signed({1'b0, s1_gain});
        scaled = prod >>> FRAC;
        if (!s1_en)             result = {{(OUT_W-RAW_W){1'b0}}, s1_raw};
        else if (scaled > MAXV) result = MAXV[OUT_W-1:0];
        else if (scaled < MINV) result = MINV[OUT_W-1:0];
        else                    result = scaled[OUT_W-1:0];
    end

    // Stage two: register the result; suppress valid while the divider holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid && !hold;
            if (s1_valid) out_data <= result;
        end
    end

    // R2
    property latency_p;
        @(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid, 2);
    endproperty
    latency_chk: assert property (latency_p);
endmodule

// File: rtl/dcal_autofind.sv
// Learning engine. It averages 2**AVG_LOG2 samples per slot and either
// hands the means over as offsets or divides the offset-corrected A level
// by the B level, one input at a time, to produce B-side gains.
// Assumes start pulses arrive only while idle; other pulses are ignored.
module dcal_autofind
    import dcal_pkg::*;
#(
    parameter int N_IN     = 2,
    parameter int RAW_W    = 20,
    parameter int GAIN_W   = 18,
    parameter int FRAC     = 16,
    parameter int AVG_LOG2 = 8,
    localparam int N_SLOT = 2 * N_IN,
    localparam int SLOT_W = $clog2(N_SLOT),
    localparam int CH_W   = $clog2(N_IN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go_off,
    input  logic                          go_gain,
    input  logic                          smp_valid,
    input  logic [SLOT_W-1:0]             smp_slot,
    input  logic [RAW_W-1:0]              smp_raw,
    input  logic [N_SLOT-1:0][RAW_W-1:0]  cur_off,
    output logic                          off_load,
    output logic [N_SLOT-1:0][RAW_W-1:0]  mean,
    output logic                          gain_load,
    output logic [SLOT_W-1:0]             gain_slot,
    output logic [GAIN_W-1:0]             gain_val,
    output logic                          busy,
    output logic                          done
);
    localparam int AVG_N = 1 << AVG_LOG2;
    localparam int ACC_W = RAW_W + AVG_LOG2;
    localparam int CNT_W = AVG_LOG2 + 1;
    localparam int DW    = RAW_W + FRAC;
    localparam int BC_W  = $clog2(DW + 1);

    af_state_e        state;
    logic [ACC_W-1:0] acc [N_SLOT];
    logic [CNT_W-1:0] cnt [N_SLOT];
    logic [N_SLOT-1:0] full;
    logic acc_clr, acc_on;

    logic [CH_W-1:0]  ch;
    logic             run;
    logic [DW-1:0]    dvd, quo;
    logic [RAW_W-1:0] rem, dsr;
    logic [BC_W-1:0]  bits;
    logic [RAW_W-1:0] m_a, m_b, o_a, o_b, lvl_a, lvl_b;
    logic [RAW_W:0]   trial;

    assign acc_clr = (state == AF_IDLE) && (go_off || go_gain);
    assign acc_on  = (state == AF_OFFSET) || (state == AF_GAIN);
    assign busy    = (state == AF_DIVIDE);

    for (genvar i = 0; i < N_SLOT; i++) begin : g_acc
        // Sums the first AVG_N samples of slot i and drops the rest.
        always_ff @(posedge clk) begin
            if (!rst_n || acc_clr) begin
                acc[i] <= '0;
                cnt[i] <= '0;
            end else if (acc_on && smp_valid && smp_slot == SLOT_W'(i) && !full[i]) begin
                acc[i] <= acc[i] + ACC_W'(smp_raw);
                cnt[i] <= cnt[i] + 1'b1;
            end
        end
        assign full[i] = (cnt[i] == CNT_W'(AVG_N));
        assign mean[i] = acc[i][ACC_W-1:AVG_LOG2];

        // R7
        cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[i] <= CNT_W'(AVG_N));
    end

    // Offset-corrected A and B levels of the input being divided, floored at 0.
    always_comb begin
        m_a   = mean[{ch, 1'b0}];
        m_b   = mean[{ch, 1'b1}];
        o_a   = cur_off[{ch, 1'b0}];
        o_b   = cur_off[{ch, 1'b1}];
        lvl_a = (m_a > o_a) ? m_a - o_a : '0;
        lvl_b = (m_b > o_b) ? m_b - o_b : '0;
        trial = {rem, dvd[DW-1]};
    end

    // Sequence control plus a restoring divider, one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= AF_IDLE;
            done      <= 1'b0;
            off_load  <= 1'b0;
            gain_load <= 1'b0;
            gain_slot <= '0;
            gain_val  <= '0;
            ch        <= '0;
            run       <= 1'b0;
            dvd       <= '0;
            quo       <= '0;
            rem       <= '0;
            dsr       <= '0;
            bits      <= '0;
        end else begin
            off_load  <= 1'b0;
            gain_load <= 1'b0;
            case (state)
                AF_IDLE: begin
                    if (go_off) begin
                        state <= AF_OFFSET;
                        done  <= 1'b0;
                    end else if (go_gain) begin
                        state <= AF_GAIN;
                        done  <= 1'b0;
                    end
                end
                AF_OFFSET: if (&full) begin
                    off_load <= 1'b1;
                    done     <= 1'b1;
                    state    <= AF_IDLE;
                end
                AF_GAIN: if (&full) begin
                    state <= AF_DIVIDE;
                    ch    <= '0;
                    run   <= 1'b0;
                end
                AF_DIVIDE: begin
                    if (!run) begin
                        dvd  <= {lvl_a, {FRAC{1'b0}}};
                        dsr  <= lvl_b;
                        rem  <= '0;
                        quo  <= '0;
                        bits <= BC_W'(DW);
                        run  <= 1'b1;
                    end else if (bits != '0) begin
                        if (trial >= {1'b0, dsr}) begin
                            rem <= RAW_W'(trial - {1'b0, dsr});
                            quo <= {quo[DW-2:0], 1'b1};
                        end else begin
                            rem <= trial[RAW_W-1:0];
                            quo <= {quo[DW-2:0], 1'b0};
                        end
                        dvd  <= dvd << 1;
                        bits <= bits - 1'b1;
                    end else begin
                        gain_load <= 1'b1;
                        gain_slot <= {ch, 1'b1};
                        gain_val  <= (|quo[DW-1:GAIN_W]) ? {GAIN_W{1'b1}} : quo[GAIN_W-1:0];
                        run       <= 1'b0;
                        if (ch == CH_W'(N_IN - 1)) begin
                            state <= AF_IDLE;
                            done  <= 1'b1;
                        end else begin
                            ch <= ch + 1'b1;
                        end
                    end
                end
                default: state <= AF_IDLE;
            endcase
        end
    end

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state == AF_IDLE);
endmodule

// File: rtl/dualside_cal.sv
// Top of the dual-side offset/gain corrector. It routes each sample's
// slot {chan, side} to the coefficient bank, keeps the correction enable
// and ties the learning engine to the bank and the datapath.
// Assumes one sample per cycle at most and strobes of one cycle.
module dualside_cal
    import dcal_pkg::*;
#(
    parameter int N_IN     = 2,
    parameter int RAW_W    = 20,
    parameter int GAIN_W   = 18,
    parameter int FRAC     = 16,
    parameter int OUT_W    = 24,
    parameter int AVG_LOG2 = 8,
    localparam int CH_W   = $clog2(N_IN),
    localparam int N_SLOT = 2 * N_IN,
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [CH_W-1:0]  in_chan,
    input  logic             in_side,
    input  logic [RAW_W-1:0] in_raw,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic             wr_side,
    input  logic             wr_gain,
    input  logic [RAW_W-1:0] wr_data,
    input  logic             cal_on_stb,
    input  logic             cal_off_stb,
    input  logic             af_offset_go,
    input  logic             af_gain_go,
    output logic             af_done,
    output logic             cal_active,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    logic [SLOT_W-1:0]             slot;
    logic [N_SLOT-1:0][RAW_W-1:0]  offset, mean;
    logic [N_SLOT-1:0][GAIN_W-1:0] gain;
    logic                          off_load, gain_load, af_busy;
    logic [SLOT_W-1:0]             gain_slot;
    logic [GAIN_W-1:0]             gain_val;

    assign slot = {in_chan, in_side};

    // Correction enable: strobes and a finished offset run set it; off clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_active <= 1'b0;
        end else begin
            if (cal_off_stb)             cal_active <= 1'b0;
            if (cal_on_stb || off_load)  cal_active <= 1'b1;
        end
    end

    dcal_coef_bank #(
        .N_SLOT(N_SLOT), .RAW_W(RAW_W), .GAIN_W(GAIN_W), .FRAC(FRAC)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot({wr_chan, wr_side}), .wr_gain(wr_gain), .wr_data(wr_data),
        .off_load(off_load), .off_mean(mean),
        .gain_load(gain_load), .gain_slot(gain_slot), .gain_val(gain_val),
        .offset(offset), .gain(gain)
    );

    dcal_autofind #(
        .N_IN(N_IN), .RAW_W(RAW_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .AVG_LOG2(AVG_LOG2)
    ) u_learn (
        .clk(clk), .rst_n(rst_n),
        .go_off(af_offset_go), .go_gain(af_gain_go),
        .smp_valid(in_valid), .smp_slot(slot), .smp_raw(in_raw),
        .cur_off(offset),
        .off_load(off_load), .mean(mean),
        .gain_load(gain_load), .gain_slot(gain_slot), .gain_val(gain_val),
        .busy(af_busy), .done(af_done)
    );

    dcal_datapath #(
        .RAW_W(RAW_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .OUT_W(OUT_W)
    ) u_path (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_raw(in_raw),
        .coef_off(offset[slot]), .coef_gain(gain[slot]),
        .cal_en(cal_active), .hold(af_busy),
        .out_valid(out_valid), .out_data(out_data)
    );

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        af_busy |=> !out_valid);

    // R4
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && !$past(cal_active, 2) && !$past(af_busy))
        |-> (out_valid && out_data == {{(OUT_W-RAW_W){1'b0}}, $past(in_raw, 2)}));

    // R7
    enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_active) |-> ($past(cal_on_stb) || $past(off_load)));
endmodule

// File: tb/tb_dualside_cal.sv
module tb_dualside_cal;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_chan, in_side;
    logic [19:0] in_raw;
    logic        wr_en, wr_chan, wr_side, wr_gain;
    logic [19:0] wr_data;
    logic        cal_on_stb, cal_off_stb, af_offset_go, af_gain_go;
    logic        af_done, cal_active, out_valid;
    logic [23:0] out_data;

    int errors = 0;
    int checks = 0;
    longint off_m [4];
    longint gain_m [4];
    bit en_m;

    dualside_cal dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model(input int s, input longint raw);
        longint v;
        if (!en_m) return raw;
        v = ((raw - off_m[s]) * gain_m[s]) >>> 16;
        if (v > 8388607) v = 8388607;
        if (v < -8388608) v = -8388608;
        return v;
    endfunction

    task automatic sample(input int s, input longint raw, output longint got, output bit v);
        @(negedge clk);
        in_valid = 1'b1; in_chan = s[1]; in_side = s[0]; in_raw = raw[19:0];
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        v = out_valid;
        got = $signed(out_data);
    endtask

    task automatic check_sample(input int s, input longint raw, input string req);
        longint got, exp;
        bit v;
        sample(s, raw, got, v);
        exp = model(s, raw);
        chk(v && got == exp, req, got, exp);
    endtask

    task automatic push(input int s, input longint raw);
        @(negedge clk);
        in_valid = 1'b1; in_chan = s[1]; in_side = s[0]; in_raw = raw[19:0];
    endtask

    task automatic write_coef(input int s, input bit g, input longint val);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = s[1]; wr_side = s[0]; wr_gain = g; wr_data = val[19:0];
        @(negedge clk);
        wr_en = 1'b0;
        if (g) gain_m[s] = val; else off_m[s] = val;
    endtask

    task automatic set_enable(input bit on);
        @(negedge clk);
        if (on) cal_on_stb = 1'b1; else cal_off_stb = 1'b1;
        @(negedge clk);
        cal_on_stb = 1'b0; cal_off_stb = 1'b0;
        en_m = on;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        longint got, exp, sum [4], va [2], vb [2], la, lb, g;
        bit v;
        rst_n = 1'b0; in_valid = 1'b0; in_chan = 1'b0; in_side = 1'b0; in_raw = '0;
        wr_en = 1'b0; wr_chan = 1'b0; wr_side = 1'b0; wr_gain = 1'b0; wr_data = '0;
        cal_on_stb = 1'b0; cal_off_stb = 1'b0; af_offset_go = 1'b0; af_gain_go = 1'b0;
        for (int s = 0; s < 4; s++) begin off_m[s] = 0; gain_m[s] = 65536; end
        en_m = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!out_valid, "R1 out_valid", out_valid, 0);
        chk(!cal_active, "R1 cal_active", cal_active, 0);
        chk(!af_done, "R1 af_done", af_done, 0);
        set_enable(1'b1);
        for (int s = 0; s < 4; s++) check_sample(s, 12345 + s, "R1 unity");

        // R2 R3 sweep all slots, alternating sides
        write_coef(0, 1'b0, 1000);  write_coef(0, 1'b1, 65536);
        write_coef(1, 1'b0, 2000);  write_coef(1, 1'b1, 70000);
        write_coef(2, 1'b0, 50000); write_coef(2, 1'b1, 40000);
        write_coef(3, 1'b0, 7);     write_coef(3, 1'b1, 131071);
        for (int k = 0; k < 32; k++)
            for (int s = 0; s < 4; s++)
                check_sample(s, longint'(k) * 33825, "R2 R3 sweep");

        // R4 bypass keeps coefficients
        set_enable(1'b0);
        for (int s = 0; s < 4; s++) check_sample(s, 400000 + s, "R4 bypass");
        set_enable(1'b1);
        for (int s = 0; s < 4; s++) check_sample(s, 400000 + s, "R4 reuse");

        // R5 write and sample in the same cycle
        @(negedge clk);
        in_valid = 1'b1; in_chan = 1'b0; in_side = 1'b0; in_raw = 20'd30000;
        wr_en = 1'b1; wr_chan = 1'b0; wr_side = 1'b0; wr_gain = 1'b0; wr_data = 20'd5000;
        @(negedge clk);
        in_valid = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        exp = model(0, 30000);
        chk(out_valid && $signed(out_data) == exp, "R5 old coefficient", $signed(out_data), exp);
        off_m[0] = 5000;
        check_sample(0, 30000, "R5 new coefficient");

        // R6 extremes
        write_coef(1, 1'b0, 0);       write_coef(1, 1'b1, 20'h3FFFF);
        write_coef(2, 1'b0, 20'hFFFFF); write_coef(2, 1'b1, 20'h3FFFF);
        check_sample(1, 20'hFFFFF, "R6 top");
        check_sample(2, 0, "R6 bottom");
        check_sample(2, 20'hFFFFF, "R6 zero");

        // R7 R8 offset learning
        @(negedge clk); af_offset_go = 1'b1;
        @(negedge clk); af_offset_go = 1'b0;
        chk(!af_done, "R8 done low after start", af_done, 0);
        for (int s = 0; s < 4; s++) sum[s] = 0;
        for (int r = 0; r < 264; r++) begin
            for (int s = 0; s < 4; s++) begin
                longint raw;
                raw = (r < 256) ? 1000 + 100 * s + ((r * 37 + s * 11) % 64) : 20'hFFFFF;
                if (r < 256) sum[s] += raw;
                push(s, raw);
            end
            if (r == 128) chk(!af_done, "R8 done low while averaging", af_done, 0);
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(af_done, "R8 done high", af_done, 1);
        chk(cal_active, "R7 enable set", cal_active, 1);
        en_m = 1'b1;
        for (int s = 0; s < 4; s++) off_m[s] = sum[s] >>> 8;
        for (int s = 0; s < 4; s++) check_sample(s, off_m[s] + 500, "R7 learned offset");

        // R9 R10 gain matching
        va[0] = 600000; vb[0] = 580000;
        va[1] = 300000; vb[1] = off_m[3] + 50;
        @(negedge clk); af_gain_go = 1'b1;
        @(negedge clk); af_gain_go = 1'b0;
        chk(!af_done, "R8 done low after gain start", af_done, 0);
        for (int r = 0; r < 256; r++)
            for (int s = 0; s < 4; s++)
                push(s, s[0] ? vb[s/2] : va[s/2]);
        sample(0, 777, got, v);
        chk(!v, "R10 valid held while dividing", v, 0);
        for (int t = 0; t < 300 && !af_done; t++) @(negedge clk);
        chk(af_done, "R9 done after divide", af_done, 1);
        for (int c = 0; c < 2; c++) begin
            la = va[c] - off_m[2*c];   if (la < 0) la = 0;
            lb = vb[c] - off_m[2*c+1]; if (lb < 0) lb = 0;
            g = (lb == 0) ? 262143 : (la * 65536) / lb;
            if (g > 262143) g = 262143;
            gain_m[2*c+1] = g;
        end
        chk(gain_m[3] == 262143, "R9 clamp case reached", gain_m[3], 262143);
        for (int s = 0; s < 4; s++) check_sample(s, s[0] ? vb[s/2] : va[s/2], "R9 matched gain");
        for (int s = 0; s < 4; s++) check_sample(s, 200000 + 3 * s, "R9 coefficients");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule